// File: doc/BRIEF.md
# Omega Multistage Request Router

This block steers memory requests from eight CPU-side ports to eight memory-side ports through a shuffle-exchange interconnect. The interconnect has log2(N) columns of two-by-two switching elements, N/2 elements per column, with a perfect-shuffle permutation (left rotation of the line index) ahead of every column. A request carries three fields: a destination module number, an address inside that module, and an operation code. Each column looks at one bit of the module number, most significant bit first, to choose its element's upper output (bit 0) or lower output (bit 1).

When a column has used its bit, it overwrites that bit with the number of the element input the request came in on (0 upper, 1 lower). By the time a request reaches the memory side, the module field has become a return tag that names the CPU which issued it, so a reply can follow the same path back. The network is blocking. When both inputs of an element want the same output in the same cycle, the upper input proceeds and the lower request is discarded. The CPU that issued the lost request is then told through a one-cycle blocked pulse. Retrying is up to the requester.

Every column is registered, so the network is a three-stage pipeline that can accept a new set of requests on every clock.

Top module: `omega_net`

## Requirements
- R1: After reset, and after a reset applied while requests are in flight, `mem_valid` and `cpu_blocked` are all zero, and no request issued before the reset ever appears at the memory side.
- R2: A request that is not blocked appears with `mem_valid` set on the memory port whose index equals its module number exactly three rising clock edges after the edge that captured it. It appears on no other edge.
- R3: The address and opcode of a delivered request arrive unchanged.
- R4: The return tag on `mem_tag` of a delivered request equals the index of the CPU port that issued it. Tag bit 2 is written by the first column, bit 1 by the second and bit 0 by the third, each with the element input number (0 upper, 1 lower).
- R5: Column k routes on module bit (2-k), with 0 selecting the upper output and 1 the lower output. With perfect-shuffle wiring, every cyclic shift of the ports (module = CPU index + c mod 8), with all eight ports active, is delivered without any blocking.
- R6: When both inputs of an element want the same output in one cycle, the upper input is forwarded and the lower input's request is discarded.
- R7: A discarded request never appears at the memory side, and no request appears there that was not issued.
- R8: A request discarded in column k raises `cpu_blocked` at its issuing CPU's index for exactly one cycle, k+1 rising edges after the edge that captured the request.
- R9: Requests issued on consecutive cycles travel independently: each set is delivered or blocked exactly as it would be alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 8 | Per-CPU request present |
| cpu_module | input | 24 | Per-CPU destination module, 3 bits per port |
| cpu_addr | input | 64 | Per-CPU address within the module, 8 bits per port |
| cpu_op | input | 16 | Per-CPU operation code, 2 bits per port |
| cpu_blocked | output | 8 | One-cycle pulse: this CPU's request was discarded |
| mem_valid | output | 8 | Per-module request present |
| mem_tag | output | 24 | Return tag (issuing CPU index), 3 bits per port |
| mem_addr | output | 64 | Delivered address, 8 bits per port |
| mem_op | output | 16 | Delivered opcode, 2 bits per port |

## Verification
Inputs are applied between edges, and results are read at the falling edge that follows each rising edge. Delivered requests are due after the third rising edge. A blocked pulse is due after the first, second or third edge, depending on the column that discarded the request. The vector walk issues one request set, ORs `cpu_blocked` over the three following samples, and compares the memory side at the third sample. Directed tests then pin each blocked pulse and each delivery to its exact sample, and also check the samples before and after it.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect shuffle: left rotation of an LG-bit line index.
  function automatic int shuffle_left(int idx, int lg);
    return ((idx << 1) | (idx >> (lg - 1))) & ((1 << lg) - 1);
  endfunction

  // Inverse shuffle: which previous line feeds position idx.
  function automatic int shuffle_right(int idx, int lg);
    return ((idx >> 1) | ((idx & 1) << (lg - 1))) & ((1 << lg) - 1);
  endfunction

  // Source CPU of a request lost in column `stage` at shuffled position
  // `pos`: upper bits are already stamped in the module field, the next
  // bit is the element port, the rest sit in the top of the position.
  function automatic int lost_source(int stage, int modf, int pos, int lg);
    int src;
    src = 0;
    for (int b = 0; b < lg; b++) begin
      int bitv;
      if (b > lg - 1 - stage)       bitv = (modf >> b) & 1;
      else if (b == lg - 1 - stage) bitv = pos & 1;
      else                          bitv = (pos >> (b + stage + 1)) & 1;
      src = src | (bitv << b);
    end
    return src;
  endfunction

endpackage

// File: rtl/omega_switch2.sv
module omega_switch2 #(
  parameter int MSG_W   = 13,
  parameter int SEL_POS = 12
) (
  input  logic [1:0]            in_valid,
  input  logic [1:0][MSG_W-1:0] in_msg,
  output logic [1:0]            out_valid,
  output logic [1:0][MSG_W-1:0] out_msg,
  output logic                  lower_lost
);

  logic want_up, want_lo, clash, pass_lo;

  function automatic logic [MSG_W-1:0] stamp(logic [MSG_W-1:0] m, logic port);
    logic [MSG_W-1:0] r;
    r = m;
    r[SEL_POS] = port;
    return r;
  endfunction

  always_comb begin
    want_up = in_msg[0][SEL_POS];
    want_lo = in_msg[1][SEL_POS];
    clash   = in_valid[0] && in_valid[1] && (want_up == want_lo);
    pass_lo = in_valid[1] && !clash;
    for (int o = 0; o < 2; o++) begin
      if (in_valid[0] && (want_up == 1'(o))) begin
        out_valid[o] = 1'b1;
        out_msg[o]   = stamp(in_msg[0], 1'b0);
      end else begin
        out_valid[o] = pass_lo && (want_lo == 1'(o));
        out_msg[o]   = stamp(in_msg[1], 1'b1);
      end
    end
  end

  assign lower_lost = clash;

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int LOG_PORTS = 3,
  parameter int MSG_W     = 13,
  parameter int STAGE     = 0,
  localparam int NPORT    = 1 << LOG_PORTS,
  localparam int SEL_POS  = MSG_W - LOG_PORTS + (LOG_PORTS - 1 - STAGE)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPORT-1:0]            in_valid,
  input  logic [NPORT-1:0][MSG_W-1:0] in_msg,
  output logic [NPORT-1:0]            out_valid,
  output logic [NPORT-1:0][MSG_W-1:0] out_msg,
  output logic [NPORT-1:0]            lost_src
);
  import omega_pkg::*;

  logic [NPORT-1:0]            sh_valid;
  logic [NPORT-1:0][MSG_W-1:0] sh_msg;
  logic [NPORT-1:0]            sw_valid;
  logic [NPORT-1:0][MSG_W-1:0] sw_msg;
  logic [NPORT/2-1:0]          sw_lost;

  genvar p, j;
  generate
    for (p = 0; p < NPORT; p++) begin : g_shuffle
      assign sh_valid[p] = in_valid[shuffle_right(p, LOG_PORTS)];
      assign sh_msg[p]   = in_msg[shuffle_right(p, LOG_PORTS)];
    end

    for (j = 0; j < NPORT/2; j++) begin : g_elem
      omega_switch2 #(.MSG_W(MSG_W), .SEL_POS(SEL_POS)) u_sw (
        .in_valid  (sh_valid[2*j+1:2*j]),
        .in_msg    (sh_msg[2*j+1:2*j]),
        .out_valid (sw_valid[2*j+1:2*j]),
        .out_msg   (sw_msg[2*j+1:2*j]),
        .lower_lost(sw_lost[j])
      );

      // element neither creates nor loses requests beyond the flagged one
      assert_elem_conserves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sw_valid[2*j+1:2*j]) + int'(sw_lost[j]) == $countones(sh_valid[2*j+1:2*j]));
      // a loss only happens when the upper input is contending
      assert_lower_yields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_lost[j] |-> (sh_valid[2*j] && sh_valid[2*j+1]));
    end
  endgenerate

  always_comb begin
    lost_src = '0;
    for (int k = 0; k < NPORT/2; k++) begin
      if (sw_lost[k])
        lost_src[LOG_PORTS'(lost_source(STAGE,
                   int'(sh_msg[2*k+1][MSG_W-1 -: LOG_PORTS]), 2*k+1, LOG_PORTS))] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_msg   <= '0;
    end else begin
      out_valid <= sw_valid;
      out_msg   <= sw_msg;
    end
  end

  // registered column: survivors of last cycle = arrivals minus losses
  assert_stage_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_valid) |=> $countones(out_valid) == $past($countones(in_valid)) - $past($countones(lost_src)));
  assert_stage_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|in_valid) |=> out_valid == '0);

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int LOG_PORTS = 3,
  parameter int ADDR_W    = 8,
  parameter int OP_W      = 2,
  localparam int NPORT    = 1 << LOG_PORTS,
  localparam int MSG_W    = LOG_PORTS + ADDR_W + OP_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPORT-1:0]            cpu_valid,
  input  logic [NPORT*LOG_PORTS-1:0]  cpu_module,
  input  logic [NPORT*ADDR_W-1:0]     cpu_addr,
  input  logic [NPORT*OP_W-1:0]       cpu_op,
  output logic [NPORT-1:0]            cpu_blocked,
  output logic [NPORT-1:0]            mem_valid,
  output logic [NPORT*LOG_PORTS-1:0]  mem_tag,
  output logic [NPORT*ADDR_W-1:0]     mem_addr,
  output logic [NPORT*OP_W-1:0]       mem_op
);

  logic [NPORT-1:0]            lvl_valid [LOG_PORTS+1];
  logic [NPORT-1:0][MSG_W-1:0] lvl_msg   [LOG_PORTS+1];
  logic [NPORT-1:0]            stg_lost  [LOG_PORTS];
  logic [NPORT-1:0]            any_lost;

  genvar s, k, m;
  generate
    for (s = 0; s < NPORT; s++) begin : g_pack
      assign lvl_msg[0][s] = {cpu_module[s*LOG_PORTS +: LOG_PORTS],
                              cpu_addr[s*ADDR_W +: ADDR_W],
                              cpu_op[s*OP_W +: OP_W]};
    end
    assign lvl_valid[0] = cpu_valid;

    for (k = 0; k < LOG_PORTS; k++) begin : g_col
      omega_stage #(.LOG_PORTS(LOG_PORTS), .MSG_W(MSG_W), .STAGE(k)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (lvl_valid[k]),
        .in_msg   (lvl_msg[k]),
        .out_valid(lvl_valid[k+1]),
        .out_msg  (lvl_msg[k+1]),
        .lost_src (stg_lost[k])
      );
    end

    for (m = 0; m < NPORT; m++) begin : g_unpack
      assign mem_tag[m*LOG_PORTS +: LOG_PORTS] = lvl_msg[LOG_PORTS][m][MSG_W-1 -: LOG_PORTS];
      assign mem_addr[m*ADDR_W +: ADDR_W]      = lvl_msg[LOG_PORTS][m][OP_W +: ADDR_W];
      assign mem_op[m*OP_W +: OP_W]            = lvl_msg[LOG_PORTS][m][OP_W-1:0];
    end
  endgenerate

  assign mem_valid = lvl_valid[LOG_PORTS];

  always_comb begin
    any_lost = '0;
    for (int c = 0; c < LOG_PORTS; c++) any_lost = any_lost | stg_lost[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_blocked <= '0;
    else        cpu_blocked <= any_lost;
  end

  // delivered request came from the tagged CPU three edges earlier
  generate
    for (m = 0; m < NPORT; m++) begin : g_chk_mem
      for (s = 0; s < NPORT; s++) begin : g_chk_src
        assert_route_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
          (mem_valid[m] && mem_tag[m*LOG_PORTS +: LOG_PORTS] == LOG_PORTS'(s)) |->
          ($past(cpu_valid[s], 3) && $past(cpu_module[s*LOG_PORTS +: LOG_PORTS], 3) == LOG_PORTS'(m)));
      end
    end
    for (s = 0; s < NPORT; s++) begin : g_chk_blk
      assert_blocked_had_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_blocked[s] |-> ($past(cpu_valid[s], 1) || $past(cpu_valid[s], 2) || $past(cpu_valid[s], 3)));
    end
  endgenerate

endmodule

// File: tb/omega_net_tb_top.sv
module omega_net_tb_top;

  localparam int LG = 3;
  localparam int NP = 8;
  localparam int AW = 8;
  localparam int OW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     cpu_valid = '0;
  logic [NP*LG-1:0]  cpu_module = '0;
  logic [NP*AW-1:0]  cpu_addr = '0;
  logic [NP*OW-1:0]  cpu_op = '0;
  logic [NP-1:0]     cpu_blocked;
  logic [NP-1:0]     mem_valid;
  logic [NP*LG-1:0]  mem_tag;
  logic [NP*AW-1:0]  mem_addr;
  logic [NP*OW-1:0]  mem_op;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  omega_net #(.LOG_PORTS(LG), .ADDR_W(AW), .OP_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_module(cpu_module), .cpu_addr(cpu_addr), .cpu_op(cpu_op),
    .cpu_blocked(cpu_blocked),
    .mem_valid(mem_valid), .mem_tag(mem_tag), .mem_addr(mem_addr), .mem_op(mem_op)
  );

  // entry: {valid mask, modules cpu7..cpu0, delivered mask, blocked mask}
  localparam logic [47:0] VEC [9] = '{
    {8'hFF, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'hFF, 8'h00}, // R5 identity
    {8'hFF, {3'd2,3'd1,3'd0,3'd7,3'd6,3'd5,3'd4,3'd3}, 8'hFF, 8'h00}, // R5 shift 3
    {8'hFF, {3'd5,3'd5,3'd5,3'd5,3'd5,3'd5,3'd5,3'd5}, 8'h01, 8'hFE}, // R6 all to one
    {8'hFF, {3'd7,3'd3,3'd5,3'd1,3'd6,3'd2,3'd4,3'd0}, 8'h0F, 8'hF0}, // R6 bit reversal
    {8'hC8, {3'd0,3'd1,3'd0,3'd0,3'd6,3'd0,3'd0,3'd0}, 8'hC8, 8'h00}, // sparse, lower alone
    {8'h05, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd3,3'd0,3'd2}, 8'h01, 8'h04}, // R6 column 1 clash
    {8'h03, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd7,3'd7}, 8'h01, 8'h02}, // R6 column 2 clash
    {8'h22, {3'd0,3'd0,3'd1,3'd0,3'd0,3'd0,3'd0,3'd0}, 8'h02, 8'h20}, // R6 column 0 clash
    {8'hFF, {3'd0,3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1}, 8'hFF, 8'h00}  // R5 shift 1
  };

  function automatic logic [AW-1:0] addr_of(int tagv, int s);
    return AW'((tagv * 16 + s * 3 + 5) % 256);
  endfunction
  function automatic logic [OW-1:0] op_of(int tagv, int s);
    return OW'((tagv + s) % 4);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] vm, input logic [23:0] mods, input int tagv);
    cpu_valid  = vm;
    cpu_module = mods;
    for (int s = 0; s < NP; s++) begin
      cpu_addr[s*AW +: AW] = addr_of(tagv, s);
      cpu_op[s*OW +: OW]   = op_of(tagv, s);
    end
  endtask

  task automatic idle();
    cpu_valid = '0;
  endtask

  task automatic check_mem(input logic [7:0] pass, input logic [23:0] mods,
                           input int tagv, input string req);
    logic [7:0] expm;
    expm = '0;
    for (int s = 0; s < NP; s++)
      if (pass[s]) expm[mods[s*LG +: LG]] = 1'b1;
    chk(mem_valid == expm, req, "mem_valid", 64'(mem_valid), 64'(expm));
    for (int s = 0; s < NP; s++) begin
      if (pass[s]) begin
        int m;
        m = int'(mods[s*LG +: LG]);
        chk(mem_tag[m*LG +: LG] == LG'(s), "R4", "return tag", 64'(mem_tag[m*LG +: LG]), 64'(s));
        chk(mem_addr[m*AW +: AW] == addr_of(tagv, s) && mem_op[m*OW +: OW] == op_of(tagv, s),
            "R3", "addr/op", 64'({mem_addr[m*AW +: AW], mem_op[m*OW +: OW]}),
            64'({addr_of(tagv, s), op_of(tagv, s)}));
      end
    end
  endtask

  // blocked pulse expected after edge 1, 2, 3 and nothing after edge 4
  task automatic blk_timing(input int vi, input logic [7:0] e1, input logic [7:0] e2,
                            input logic [7:0] e3);
    @(negedge clk); put(VEC[vi][47:40], VEC[vi][39:16], 40 + vi);
    @(negedge clk); idle();
    chk(cpu_blocked == e1, "R8", "blocked after edge 1", 64'(cpu_blocked), 64'(e1));
    @(negedge clk);
    chk(cpu_blocked == e2, "R8", "blocked after edge 2", 64'(cpu_blocked), 64'(e2));
    @(negedge clk);
    chk(cpu_blocked == e3, "R8", "blocked after edge 3", 64'(cpu_blocked), 64'(e3));
    check_mem(VEC[vi][15:8], VEC[vi][39:16], 40 + vi, "R7");
    @(negedge clk);
    chk(cpu_blocked == 8'h00, "R8", "blocked after edge 4", 64'(cpu_blocked), 64'h0);
    chk(mem_valid == 8'h00, "R2", "mem_valid after edge 4", 64'(mem_valid), 64'h0);
  endtask

  initial begin
    #(20 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(mem_valid == 8'h00, "R1", "mem_valid in reset", 64'(mem_valid), 64'h0);
    chk(cpu_blocked == 8'h00, "R1", "cpu_blocked in reset", 64'(cpu_blocked), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_valid == 8'h00, "R1", "mem_valid after reset", 64'(mem_valid), 64'h0);

    // vector walk: R5, R6, R7 plus R3/R4 on every delivery
    for (int v = 0; v < 9; v++) begin
      logic [7:0] blk;
      @(negedge clk); put(VEC[v][47:40], VEC[v][39:16], v);
      @(negedge clk); idle();
      blk = cpu_blocked;
      @(negedge clk); blk = blk | cpu_blocked;
      @(negedge clk); blk = blk | cpu_blocked;
      check_mem(VEC[v][15:8], VEC[v][39:16], v, "R5_R6_R7");
      chk(blk == VEC[v][7:0], "R6", "blocked set", 64'(blk), 64'(VEC[v][7:0]));
    end

    // R2 exact delivery edge
    @(negedge clk); put(8'h08, {3'd0,3'd0,3'd0,3'd0,3'd6,3'd0,3'd0,3'd0}, 30);
    @(negedge clk); idle();
    chk(mem_valid == 8'h00, "R2", "mem_valid after edge 1", 64'(mem_valid), 64'h0);
    @(negedge clk);
    chk(mem_valid == 8'h00, "R2", "mem_valid after edge 2", 64'(mem_valid), 64'h0);
    @(negedge clk);
    chk(mem_valid == 8'h40, "R2", "mem_valid after edge 3", 64'(mem_valid), 64'h40);
    @(negedge clk);
    chk(mem_valid == 8'h00, "R2", "mem_valid after edge 4", 64'(mem_valid), 64'h0);

    // R8 blocked timing per column
    blk_timing(7, 8'h20, 8'h00, 8'h00);
    blk_timing(5, 8'h00, 8'h04, 8'h00);
    blk_timing(6, 8'h00, 8'h00, 8'h02);

    // R9 back-to-back sets: identity then all-to-module-5
    @(negedge clk); put(VEC[0][47:40], VEC[0][39:16], 50);
    @(negedge clk); put(VEC[2][47:40], VEC[2][39:16], 51);
    chk(cpu_blocked == 8'h00, "R9", "blocked edge 1", 64'(cpu_blocked), 64'h0);
    @(negedge clk); idle();
    chk(cpu_blocked == 8'hF0, "R9", "blocked edge 2", 64'(cpu_blocked), 64'hF0);
    @(negedge clk);
    chk(cpu_blocked == 8'h0C, "R9", "blocked edge 3", 64'(cpu_blocked), 64'h0C);
    check_mem(VEC[0][15:8], VEC[0][39:16], 50, "R9");
    @(negedge clk);
    chk(cpu_blocked == 8'h02, "R9", "blocked edge 4", 64'(cpu_blocked), 64'h02);
    check_mem(VEC[2][15:8], VEC[2][39:16], 51, "R9");

    // R1 reset while requests are in flight
    @(negedge clk); put(VEC[2][47:40], VEC[2][39:16], 60);
    @(negedge clk); idle(); rst_n = 1'b0;
    #1;
    chk(cpu_blocked == 8'h00, "R1", "blocked on mid-flight reset", 64'(cpu_blocked), 64'h0);
    @(negedge clk);
    chk(mem_valid == 8'h00, "R1", "mem_valid in mid-flight reset", 64'(mem_valid), 64'h0);
    rst_n = 1'b1;
    for (int e = 0; e < 3; e++) begin
      @(negedge clk);
      chk(mem_valid == 8'h00 && cpu_blocked == 8'h00, "R1", "flushed after reset",
          64'({mem_valid, cpu_blocked}), 64'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule